// File: doc/BRIEF.md
# Port-Mapped Configuration Access Bridge

This block sits on a 32-bit host I/O port bus and lets software reach the configuration space of functions behind it through two ports. It claims an 8-byte window at port 0xCF8. The dword at window offset 0 is a selector register that software loads with the target function and register offset. The dword at window offset 4 is a data port: every read or write of it becomes one configuration transaction, aimed at the target that the selector currently holds.

Each data-port access goes downstream in two steps. First a presence probe carries the function identifier, and the responder says whether that function exists. Only for a present function does an access phase follow, carrying the register offset, the direction and the write data. A read of a missing function completes with all-ones, and a write to one completes without any downstream access. The host bus waits throughout: the acknowledgement comes back only after the downstream side has answered.

Top module: `cfg_port_bridge`

## Requirements
- R1: Only port addresses 0xCF8 to 0xCFF are claimed. A request outside this window gets no io_ready, starts no downstream activity and changes no state.
- R2: A write at window offset 0 (port 0xCF8) stores all 32 bits of io_wdata in the selector. A read there returns the stored value. The value is kept across data-port accesses until offset 0 is written again, and it is 0 after reset.
- R3: Bit 31 of the selector does not affect decoding. A selector with bit 31 set sends the same identifier and offset downstream as the same value with bit 31 cleared.
- R4: cfg_bdf carries selector bits [23:8], with the bus number in cfg_bdf[15:8], the device number in cfg_bdf[7:3] and the function number in cfg_bdf[2:0]. cfg_reg carries selector bits [7:0].
- R5: A data-port access (port 0xCFC) first raises cfg_probe and holds it until a cycle with cfg_probe_done high. cfg_probe and cfg_acc are never high together.
- R6: A data-port read of a present function raises cfg_acc with cfg_acc_wr low and holds it until cfg_ack. The word on cfg_rdata in the ack cycle is returned on io_rdata.
- R7: A data-port write to a present function raises cfg_acc with cfg_acc_wr high and carries io_wdata on cfg_wdata until cfg_ack.
- R8: A data-port read of a function reported absent (cfg_present low with cfg_probe_done) returns 0xFFFFFFFF and starts no access phase.
- R9: A data-port write to an absent function completes without ever raising cfg_acc.
- R10: io_ready is a single-cycle pulse. It rises one cycle after the edge that accepts a selector access, and one cycle after the edge that sees the final downstream answer (cfg_ack, or cfg_probe_done for an absent function). Data-port latency therefore grows by one cycle for every cycle of downstream delay.
- R11: Window offsets other than 0 and 4 (ports 0xCF9 to 0xCFB and 0xCFD to 0xCFF) complete after one cycle. They read as 0, leave the selector unchanged on a write and start no downstream activity.
- R12: Out of reset, io_ready, cfg_probe and cfg_acc are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Host request, held until io_ready |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Host port address |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Read data, valid with io_ready |
| io_ready | output | 1 | One-cycle completion strobe |
| cfg_probe | output | 1 | Presence probe request |
| cfg_probe_done | input | 1 | Probe answered |
| cfg_present | input | 1 | Function exists (valid with cfg_probe_done) |
| cfg_acc | output | 1 | Configuration access request |
| cfg_acc_wr | output | 1 | Access direction, 1 = write |
| cfg_bdf | output | 16 | Bus/device/function identifier |
| cfg_reg | output | 8 | Register offset |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_ack |
| cfg_ack | input | 1 | Access completed |

## Verification
The hardest cases to reach are the wait states. The host sees only a stretched io_ready, so the behaviour in between is hidden at the port. To reach these cases, the bench's downstream responder answers probes and accesses after a programmable number of cycles. Each test sets a different pair of delays and checks the exact completion latency. Absent functions are reached by aiming the selector at identifiers the responder reports missing. The responder's own count of access phases then shows that none was issued.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_DONE   = 2'd3
    } cfgb_state_e;

endpackage

// File: rtl/cfgb_window_dec.sv
module cfgb_window_dec #(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] BASE_PORT = 16'hCF8,
    parameter int          WIN_BYTES = 8,
    parameter int          DATA_OFF  = 4
) (
    input  logic [IO_AW-1:0] io_addr,
    output logic             hit,
    output logic             sel_addr,
    output logic             sel_data
);
    localparam int OFF_W = $clog2(WIN_BYTES);

    logic [IO_AW-1:0]  base_ext;
    logic [OFF_W-1:0]  offset;

    always_comb begin
        base_ext = IO_AW'(BASE_PORT);
        offset   = io_addr[OFF_W-1:0];
        hit      = (io_addr[IO_AW-1:OFF_W] == base_ext[IO_AW-1:OFF_W]);
        sel_addr = hit && (offset == OFF_W'(0));
        sel_data = hit && (offset == OFF_W'(DATA_OFF));
    end

endmodule

// File: rtl/cfgb_target_split.sv
module cfgb_target_split #(
    parameter int DW    = 32,
    parameter int ID_W  = 16,
    parameter int REG_W = 8
) (
    input  logic [DW-1:0]    sel_value,
    output logic [ID_W-1:0]  tgt_bdf,
    output logic [REG_W-1:0] tgt_reg
);
    localparam int TOP_USED = ID_W + REG_W;

    logic [DW-1:0] masked;
    logic          unused_hi;

    always_comb begin
        masked       = sel_value;
        masked[DW-1] = 1'b0;
        tgt_bdf      = masked[TOP_USED-1:REG_W];
        tgt_reg      = masked[REG_W-1:0];
    end

    assign unused_hi = ^masked[DW-1:TOP_USED];

endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
    import cfgb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_req,
    input  logic          io_wr,
    input  logic          hit,
    input  logic          sel_addr,
    input  logic          sel_data,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic          io_ready,
    output logic [DW-1:0] sel_value,
    output logic [DW-1:0] acc_wdata,
    output logic          acc_wr,
    output logic          cfg_probe,
    input  logic          cfg_probe_done,
    input  logic          cfg_present,
    output logic          cfg_acc,
    input  logic          cfg_ack,
    input  logic [DW-1:0] cfg_rdata
);
    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

    typedef struct packed {
        cfgb_state_e   st;
        logic          wr;
        logic [DW-1:0] sel;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (io_req && hit) begin
                    s_d.wr    = io_wr;
                    s_d.wdata = io_wdata;
                    s_d.rdata = '0;
                    if (sel_data) begin
                        s_d.st = ST_PROBE;
                    end else begin
                        s_d.st = ST_DONE;
                        if (sel_addr) begin
                            if (io_wr) s_d.sel   = io_wdata;
                            else       s_d.rdata = s_q.sel;
                        end
                    end
                end
            end
            ST_PROBE: begin
                if (cfg_probe_done) begin
                    if (cfg_present) begin
                        s_d.st = ST_ACCESS;
                    end else begin
                        s_d.st    = ST_DONE;
                        s_d.rdata = s_q.wr ? '0 : ALL_ONES;
                    end
                end
            end
            ST_ACCESS: begin
                if (cfg_ack) begin
                    s_d.st    = ST_DONE;
                    s_d.rdata = s_q.wr ? '0 : cfg_rdata;
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.wr    <= 1'b0;
            s_q.sel   <= '0;
            s_q.wdata <= '0;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign io_ready  = (s_q.st == ST_DONE);
    assign io_rdata  = s_q.rdata;
    assign cfg_probe = (s_q.st == ST_PROBE);
    assign cfg_acc   = (s_q.st == ST_ACCESS);
    assign acc_wr    = s_q.wr;
    assign acc_wdata = s_q.wdata;
    assign sel_value = s_q.sel;

    a_r1_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && io_req && !hit) |=> (!io_ready && !cfg_probe && $stable(sel_value)))
        else $error("a_r1_outside_ignored");

    a_r2_sel_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE) |=> $stable(sel_value))
        else $error("a_r2_sel_held_busy");

    a_r5_probe_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_probe && !cfg_probe_done) |=> cfg_probe)
        else $error("a_r5_probe_held");

    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_probe && cfg_acc))
        else $error("a_r5_no_overlap");

    a_r6_acc_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_acc && !cfg_ack) |=> (cfg_acc && $stable(acc_wr) && $stable(acc_wdata)))
        else $error("a_r6_acc_held");

    a_r8_absent_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_probe && cfg_probe_done && !cfg_present && !acc_wr) |=> (io_ready && io_rdata == ALL_ONES))
        else $error("a_r8_absent_read_ones");

    a_r9_absent_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_probe && cfg_probe_done && !cfg_present) |=> (!cfg_acc && io_ready))
        else $error("a_r9_absent_no_access");

    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready |=> !io_ready)
        else $error("a_r10_ready_pulse");

    a_r11_other_no_probe: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && io_req && hit && !sel_data) |=> (io_ready && !cfg_probe))
        else $error("a_r11_other_no_probe");

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
    parameter int          IO_AW     = 16,
    parameter int          DW        = 32,
    parameter int          ID_W      = 16,
    parameter int          REG_W     = 8,
    parameter logic [15:0] BASE_PORT = 16'hCF8,
    parameter int          WIN_BYTES = 8,
    parameter int          DATA_OFF  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_req,
    input  logic             io_wr,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [DW-1:0]    io_wdata,
    output logic [DW-1:0]    io_rdata,
    output logic             io_ready,
    output logic             cfg_probe,
    input  logic             cfg_probe_done,
    input  logic             cfg_present,
    output logic             cfg_acc,
    output logic             cfg_acc_wr,
    output logic [ID_W-1:0]  cfg_bdf,
    output logic [REG_W-1:0] cfg_reg,
    output logic [DW-1:0]    cfg_wdata,
    input  logic [DW-1:0]    cfg_rdata,
    input  logic             cfg_ack
);
    logic          hit, sel_addr, sel_data;
    logic [DW-1:0] sel_value;

    cfgb_window_dec #(
        .IO_AW(IO_AW), .BASE_PORT(BASE_PORT),
        .WIN_BYTES(WIN_BYTES), .DATA_OFF(DATA_OFF)
    ) u_dec (
        .io_addr (io_addr),
        .hit     (hit),
        .sel_addr(sel_addr),
        .sel_data(sel_data)
    );

    cfgb_seq #(.DW(DW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .io_req        (io_req),
        .io_wr         (io_wr),
        .hit           (hit),
        .sel_addr      (sel_addr),
        .sel_data      (sel_data),
        .io_wdata      (io_wdata),
        .io_rdata      (io_rdata),
        .io_ready      (io_ready),
        .sel_value     (sel_value),
        .acc_wdata     (cfg_wdata),
        .acc_wr        (cfg_acc_wr),
        .cfg_probe     (cfg_probe),
        .cfg_probe_done(cfg_probe_done),
        .cfg_present   (cfg_present),
        .cfg_acc       (cfg_acc),
        .cfg_ack       (cfg_ack),
        .cfg_rdata     (cfg_rdata)
    );

    cfgb_target_split #(.DW(DW), .ID_W(ID_W), .REG_W(REG_W)) u_split (
        .sel_value(sel_value),
        .tgt_bdf  (cfg_bdf),
        .tgt_reg  (cfg_reg)
    );

    a_r12_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!io_ready && !cfg_probe && !cfg_acc))
        else $error("a_r12_idle_after_reset");

    a_r3_target_stable_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_probe || cfg_acc) |=> ((cfg_probe || cfg_acc || io_ready) && $stable(cfg_bdf) && $stable(cfg_reg)))
        else $error("a_r3_target_stable_in_txn");

endmodule

// File: tb/tb_cfg_port_bridge.sv
module tb_cfg_port_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0, io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_ready;
    logic        cfg_probe, cfg_probe_done = 1'b0, cfg_present = 1'b0;
    logic        cfg_acc, cfg_acc_wr, cfg_ack = 1'b0;
    logic [15:0] cfg_bdf;
    logic [7:0]  cfg_reg;
    logic [31:0] cfg_wdata, cfg_rdata = '0;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cfg_port_bridge dut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
        .cfg_probe(cfg_probe), .cfg_probe_done(cfg_probe_done), .cfg_present(cfg_present),
        .cfg_acc(cfg_acc), .cfg_acc_wr(cfg_acc_wr), .cfg_bdf(cfg_bdf), .cfg_reg(cfg_reg),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_ack(cfg_ack)
    );

    // Downstream responder model
    int p_lat = 0, a_lat = 0, p_cnt = 0, a_cnt = 0;
    int probe_starts = 0, acc_done = 0;
    bit prev_probe = 0;
    logic        last_wr;
    logic [15:0] last_bdf, probe_bdf;
    logic [7:0]  last_reg;
    logic [31:0] last_wdata;

    function automatic bit is_present(logic [15:0] b);
        return (b == 16'h0018) || (b == 16'h12FF);
    endfunction

    function automatic logic [31:0] model_data(logic [15:0] b, logic [7:0] r);
        return {b, r, 8'hC3};
    endfunction

    always @(negedge clk) begin
        cfg_probe_done = 1'b0;
        cfg_ack = 1'b0;
        if (cfg_probe && !prev_probe) probe_starts++;
        prev_probe = cfg_probe;
        if (cfg_probe) begin
            probe_bdf = cfg_bdf;
            if (p_cnt == p_lat) begin
                cfg_probe_done = 1'b1;
                cfg_present = is_present(cfg_bdf);
            end
            p_cnt++;
        end else p_cnt = 0;
        if (cfg_acc) begin
            if (a_cnt == a_lat) begin
                cfg_ack = 1'b1;
                cfg_rdata = model_data(cfg_bdf, cfg_reg);
                last_wr = cfg_acc_wr; last_bdf = cfg_bdf;
                last_reg = cfg_reg; last_wdata = cfg_wdata;
                acc_done++;
            end
            a_cnt++;
        end else a_cnt = 0;
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // One host access; returns data and cycles until io_ready (0 = none)
    task automatic io_access(input bit wr, input logic [15:0] a, input logic [31:0] d,
                             output logic [31:0] rd, output int cyc, input int limit);
        @(negedge clk);
        io_req = 1'b1; io_wr = wr; io_addr = a; io_wdata = d;
        cyc = 0; rd = '0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (io_ready) begin cyc = i; rd = io_rdata; break; end
        end
        io_req = 1'b0;
    endtask

    task automatic sel_write(input logic [31:0] v);
        logic [31:0] rd; int c;
        io_access(1, 16'hCF8, v, rd, c, 20);
    endtask

    task automatic t_reset();
        logic [31:0] rd; int c;
        check(!io_ready && !cfg_probe && !cfg_acc, "R12 outputs low after reset",
              {29'd0, io_ready, cfg_probe, cfg_acc}, 32'd0);
        io_access(0, 16'hCF8, 0, rd, c, 20);
        check(rd == 0, "R2 selector reset value", rd, 0);
    endtask

    task automatic t_sel_reg();
        logic [31:0] rd; int c;
        io_access(1, 16'hCF8, 32'h8A5A_3C0F, rd, c, 20);
        check(c == 1, "R10 selector write latency", c, 1);
        io_access(0, 16'hCF8, 0, rd, c, 20);
        check(rd == 32'h8A5A_3C0F, "R2 selector readback", rd, 32'h8A5A_3C0F);
        check(c == 1, "R10 selector read latency", c, 1);
    endtask

    task automatic t_outside();
        logic [31:0] rd; int c; int ps;
        ps = probe_starts;
        sel_write(32'h1234_5678);
        io_access(1, 16'hCF0, 32'hFFFF_FFFF, rd, c, 6);
        check(c == 0, "R1 no ready below window", c, 0);
        io_access(0, 16'hD00, 0, rd, c, 6);
        check(c == 0, "R1 no ready above window", c, 0);
        io_access(1, 16'h0CFC + 16'h1000, 0, rd, c, 6);
        check(c == 0 && probe_starts == ps, "R1 no probe for alias", c, 0);
        io_access(0, 16'hCF8, 0, rd, c, 20);
        check(rd == 32'h1234_5678, "R1 selector untouched by outside write", rd, 32'h1234_5678);
    endtask

    task automatic t_other_offsets();
        logic [31:0] rd; int c; int ps;
        ps = probe_starts;
        sel_write(32'h0000_1840);
        io_access(1, 16'hCF9, 32'hDEAD_BEEF, rd, c, 20);
        check(c == 1, "R11 offset 1 write completes", c, 1);
        io_access(0, 16'hCFA, 0, rd, c, 20);
        check(rd == 0 && c == 1, "R11 offset 2 reads zero", rd, 0);
        io_access(0, 16'hCFD, 0, rd, c, 20);
        check(rd == 0, "R11 offset 5 reads zero", rd, 0);
        io_access(1, 16'hCFF, 32'hFFFF_FFFF, rd, c, 20);
        check(probe_starts == ps, "R11 no probe from other offsets", probe_starts, ps);
        io_access(0, 16'hCF8, 0, rd, c, 20);
        check(rd == 32'h0000_1840, "R11 selector unchanged", rd, 32'h0000_1840);
    endtask

    task automatic t_present_read(input int pl, input int al);
        logic [31:0] rd; int c; logic [31:0] exp;
        p_lat = pl; a_lat = al;
        // bus 0x00, device 3, function 0 -> 0x0018
        sel_write({8'h00, 8'h00, 5'd3, 3'd0, 8'h10});
        exp = model_data(16'h0018, 8'h10);
        io_access(0, 16'hCFC, 0, rd, c, 50);
        check(rd == exp, "R6 present read data", rd, exp);
        check(last_wr == 0 && last_reg == 8'h10, "R6 access is read at reg 0x10", {last_wr, last_reg}, 9'h010);
        check(last_bdf == 16'h0018, "R4 bus/dev/fn layout", last_bdf, 16'h0018);
        check(c == 3 + pl + al, "R10 present read latency", c, 3 + pl + al);
        p_lat = 0; a_lat = 0;
    endtask

    task automatic t_present_write();
        logic [31:0] rd; int c; int ad;
        p_lat = 1; a_lat = 2;
        // bus 0x12, device 0x1F, function 7 -> 0x12FF
        sel_write({8'h00, 8'h12, 5'h1F, 3'd7, 8'h3C});
        ad = acc_done;
        io_access(1, 16'hCFC, 32'hCAFE_0042, rd, c, 50);
        check(acc_done == ad + 1 && last_wr == 1, "R7 write access issued", last_wr, 1);
        check(last_wdata == 32'hCAFE_0042, "R7 write data forwarded", last_wdata, 32'hCAFE_0042);
        check(last_bdf == 16'h12FF && last_reg == 8'h3C, "R4 target of write", {last_bdf, last_reg}, 24'h12FF3C);
        check(c == 6, "R10 write latency with delays", c, 6);
        io_access(0, 16'hCF8, 0, rd, c, 20);
        check(rd == 32'h0012_FF3C, "R2 selector held after data access", rd, 32'h0012_FF3C);
        p_lat = 0; a_lat = 0;
    endtask

    task automatic t_absent_read();
        logic [31:0] rd; int c; int ad;
        p_lat = 2;
        sel_write(32'h0000_1900);   // bus 0 dev 3 fn 1, not present
        ad = acc_done;
        io_access(0, 16'hCFC, 0, rd, c, 50);
        check(rd == 32'hFFFF_FFFF, "R8 absent read all ones", rd, 32'hFFFF_FFFF);
        check(acc_done == ad, "R8 no access phase", acc_done, ad);
        check(c == 4, "R10 absent read latency", c, 4);
        p_lat = 0;
    endtask

    task automatic t_absent_write();
        logic [31:0] rd; int c; int ad;
        sel_write(32'h0005_0000);
        ad = acc_done;
        io_access(1, 16'hCFC, 32'h1111_2222, rd, c, 50);
        check(c == 2, "R9 absent write completes", c, 2);
        check(acc_done == ad, "R9 absent write dropped", acc_done, ad);
        check(probe_bdf == 16'h0500, "R4 probe identifier", probe_bdf, 16'h0500);
    endtask

    task automatic t_bit31();
        logic [31:0] rd; int c;
        sel_write(32'h8012_FF40);
        io_access(0, 16'hCFC, 0, rd, c, 50);
        check(last_bdf == 16'h12FF && last_reg == 8'h40, "R3 bit31 set target", {last_bdf, last_reg}, 24'h12FF40);
        check(rd == model_data(16'h12FF, 8'h40), "R3 bit31 set data", rd, model_data(16'h12FF, 8'h40));
        sel_write(32'h0012_FF40);
        io_access(0, 16'hCFC, 0, rd, c, 50);
        check(last_bdf == 16'h12FF && last_reg == 8'h40, "R3 bit31 clear target", {last_bdf, last_reg}, 24'h12FF40);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sel_reg();
        t_outside();
        t_other_offsets();
        t_present_read(0, 0);
        t_present_read(3, 1);
        t_present_write();
        t_absent_read();
        t_absent_write();
        t_bit31();
        finished = 1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule